// File: doc/BRIEF.md
# Carry-less Polynomial Multiplier

This block multiplies two polynomials whose coefficients lie in GF(2). Each operand is an N-bit vector in which bit k is the coefficient of x^k. The result is their (2N-1)-bit product. The block builds one partial product for each coefficient of the second operand. A coefficient of 1 contributes a copy of the first operand shifted up by that coefficient's index, and a coefficient of 0 contributes nothing. The partial products are merged with exclusive-OR, so no carry ever moves between columns.

The whole product is formed by combinational logic in one cycle. A parameter chooses the output stage. One choice adds a result register that loads only when the input is marked valid and raises a valid flag alongside it. The other choice passes the product and the valid flag straight through. Cryptographic checksums and CRC engines use this block as the multiply step ahead of any reduction stage. It performs no modular reduction itself.

Top module: `clmul_unit`

## Requirements
- R1: The product port is 2*OP_W-1 bits wide, with OP_W defaulting to 11 (a 21-bit product). OP_W below 2 is rejected at elaboration.
- R2: For every bit i of op_b that is 1, op_a shifted left by i is XORed into the product. Bits of op_b that are 0 contribute nothing, and no carries propagate.
- R3: If either operand is all zeros, the product is all zeros.
- R4: If one operand equals 1, the product equals the other operand, zero-extended into the upper bits.
- R5: The product does not change when op_a and op_b are swapped.
- R6 (registered variant, the default): at a rising clock edge where in_valid is 1, the product of the operands present at that edge appears on product, and out_valid is 1 after that edge. After an edge with in_valid at 0, out_valid is 0.
- R7: After an edge with in_valid at 0, product keeps its previous value, whatever the operands do.
- R8: rst_n is active low and synchronous. At an edge where it is 0, product and out_valid clear to 0, and this takes priority over in_valid.
- R9: Squaring the all-ones operand gives 1s only at the even bit positions. For OP_W=11 this is 0x155555.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands are valid and are captured at this edge |
| op_a | input | OP_W | Multiplicand polynomial, bit k is the coefficient of x^k |
| op_b | input | OP_W | Multiplier polynomial, bit k is the coefficient of x^k |
| out_valid | output | 1 | product holds a newly captured result |
| product | output | 2*OP_W-1 | Carry-less product |

## Verification
Two events can land on the same edge: the reset clear and a capture by the result register. The bench holds rst_n low while in_valid is high with nonzero operands. It then expects a zero product and a low out_valid, which shows that the clear takes priority. A second overlap comes from in_valid staying high across consecutive edges with different operands. Each edge must load its own product and keep out_valid high without a gap. After each edge the result is compared with a Horner-style bit-serial model.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
   // Width of the carry-less product of two w-bit polynomials.
   function automatic int clmul_prod_w(input int w);
      return 2 * w - 1;
   endfunction
endpackage

// File: rtl/clmul_pp_gen.sv
// Builds one gated, shifted copy of the multiplicand per multiplier bit.
module clmul_pp_gen #(
   parameter int OP_W = 11,
   parameter int PW   = 2 * OP_W - 1
) (
   input  logic [OP_W-1:0]          mcand,
   input  logic [OP_W-1:0]          mplier,
   output logic [OP_W-1:0][PW-1:0]  pp
);
   localparam int EXT_W = PW - OP_W;

   logic [PW-1:0] mcand_ext;
   assign mcand_ext = {{EXT_W{1'b0}}, mcand};

   for (genvar i = 0; i < OP_W; i++) begin : g_row
      assign pp[i] = mplier[i] ? (mcand_ext << i) : '0;
   end
endmodule

// File: rtl/clmul_xor_fold.sv
// Merges all partial products with exclusive-OR, starting from zero.
module clmul_xor_fold #(
   parameter int OP_W = 11,
   parameter int PW   = 2 * OP_W - 1
) (
   input  logic [OP_W-1:0][PW-1:0]  pp,
   output logic [PW-1:0]            sum
);
   always_comb begin
      sum = '0;
      for (int i = 0; i < OP_W; i++) begin
         sum = sum ^ pp[i];
      end
   end
endmodule

// File: rtl/clmul_out_stage.sv
// Result stage: a capture register or a straight pass, chosen by parameter.
module clmul_out_stage #(
   parameter int PW         = 21,
   parameter bit REGISTERED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [PW-1:0] d,
   output logic [PW-1:0] q,
   output logic          q_valid
);
   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q       <= '0;
            q_valid <= 1'b0;
         end else begin
            q_valid <= load;
            if (load) q <= d;
         end
      end
   end else begin : g_pass
      logic unused_pass;
      assign unused_pass = &{1'b0, clk, rst_n};
      assign q       = d;
      assign q_valid = load;
   end
endmodule

// File: rtl/clmul_unit.sv
module clmul_unit
   import clmul_pkg::*;
#(
   parameter int OP_W       = 11,
   parameter bit REGISTERED = 1'b1,
   localparam int PW        = clmul_prod_w(OP_W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [OP_W-1:0] op_a,
   input  logic [OP_W-1:0] op_b,
   output logic            out_valid,
   output logic [PW-1:0]   product
);
   // R1: parameter legality checked at elaboration
   initial begin
      assert (OP_W >= 2)
         else $fatal(1, "clmul_unit: OP_W must be at least 2");
   end

   logic [OP_W-1:0][PW-1:0] pp;
   logic [PW-1:0]           comb_prod;

   clmul_pp_gen #(.OP_W(OP_W), .PW(PW)) u_pp (
      .mcand  (op_a),
      .mplier (op_b),
      .pp     (pp)
   );

   clmul_xor_fold #(.OP_W(OP_W), .PW(PW)) u_fold (
      .pp  (pp),
      .sum (comb_prod)
   );

   clmul_out_stage #(.PW(PW), .REGISTERED(REGISTERED)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (in_valid),
      .d       (comb_prod),
      .q       (product),
      .q_valid (out_valid)
   );
endmodule

// File: rtl/clmul_unit_chk.sv
module clmul_unit_chk #(
   parameter int OP_W       = 11,
   parameter bit REGISTERED = 1'b1,
   parameter int PW         = 2 * OP_W - 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [OP_W-1:0] op_a,
   input logic [OP_W-1:0] op_b,
   input logic            out_valid,
   input logic [PW-1:0]   product
);
   if (REGISTERED) begin : g_chk
      p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);

      p_valid_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);

      p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (rst_n && !in_valid) |=> $stable(product));

      p_zero_operand_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (op_a == '0 || op_b == '0)) |=> (product == '0));

      p_unit_operand_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op_b == OP_W'(1)) |=> (product == PW'($past(op_a))));

      p_reset_clear_r8: assert property (@(posedge clk)
         !rst_n |=> (!out_valid && product == '0));
   end
endmodule

bind clmul_unit clmul_unit_chk #(.OP_W(OP_W), .REGISTERED(REGISTERED), .PW(PW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_a      (op_a),
   .op_b      (op_b),
   .out_valid (out_valid),
   .product   (product)
);

// File: tb/clmul_unit_bench.sv
`timescale 1ns/1ps
module clmul_unit_bench;
   localparam int OP_W = 11;
   localparam int PW   = 2 * OP_W - 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [OP_W-1:0] op_a = '0;
   logic [OP_W-1:0] op_b = '0;
   logic            out_valid;
   logic [PW-1:0]   product;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [31:0] lfsr = 32'h1ACE_B00C;

   always #2.5 clk = ~clk;

   clmul_unit #(.OP_W(OP_W), .REGISTERED(1'b1)) u_clmul_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product)
   );

   // Horner-form bit-serial model: walk the multiplier from its top bit.
   function automatic logic [PW-1:0] ref_mul(input logic [OP_W-1:0] a,
                                             input logic [OP_W-1:0] b);
      logic [PW-1:0] r = '0;
      for (int i = OP_W - 1; i >= 0; i--) begin
         r = r << 1;
         if (b[i]) r = r ^ PW'(a);
      end
      return r;
   endfunction

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      logic [31:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // Present operands for one edge, then sample at the following falling edge.
   task automatic apply(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
      @(negedge clk);
      op_a = a; op_b = b; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R8 reset product", product, '0);
      chk("R8 reset out_valid", PW'(out_valid), '0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_zero;
      apply(11'h5A3, '0);
      chk("R3 b zero", product, '0);
      chk("R6 valid after capture", PW'(out_valid), PW'(1));
      apply('0, 11'h7FF);
      chk("R3 a zero", product, '0);
   endtask

   task automatic t_identity;
      apply(11'h6B1, 11'h001);
      chk("R4 times one", product, PW'(11'h6B1));
      apply(11'h001, 11'h4C7);
      chk("R4 one times", product, PW'(11'h4C7));
   endtask

   task automatic t_all_ones;
      apply(11'h7FF, 11'h7FF);
      chk("R9 all-ones square", product, 21'h155555);
      chk("R1 top bit", PW'(product[PW-1]), PW'(1));
   endtask

   task automatic t_random;
      for (int k = 0; k < 40; k++) begin
         logic [OP_W-1:0] a, b;
         logic [PW-1:0]   first;
         lfsr = next_rand(lfsr); a = lfsr[OP_W-1:0];
         lfsr = next_rand(lfsr); b = lfsr[OP_W-1:0];
         apply(a, b);
         first = product;
         chk("R2 random product", product, ref_mul(a, b));
         apply(b, a);
         chk("R5 swapped operands", product, first);
      end
   endtask

   task automatic t_hold;
      logic [PW-1:0] prev;
      apply(11'h2D9, 11'h13B);
      prev = product;
      @(negedge clk);
      op_a = 11'h7FF; op_b = 11'h555;
      @(negedge clk);
      chk("R7 hold when idle", product, prev);
      chk("R6 valid low when idle", PW'(out_valid), '0);
   endtask

   task automatic t_back_to_back;
      @(negedge clk);
      op_a = 11'h301; op_b = 11'h0F3; in_valid = 1'b1;
      @(negedge clk);
      chk("R6 first of pair", product, ref_mul(11'h301, 11'h0F3));
      op_a = 11'h4A5; op_b = 11'h622;
      @(negedge clk);
      chk("R6 second of pair", product, ref_mul(11'h4A5, 11'h622));
      chk("R6 valid stays high", PW'(out_valid), PW'(1));
      in_valid = 1'b0;
   endtask

   task automatic t_reset_vs_capture;
      @(negedge clk);
      rst_n = 1'b0; op_a = 11'h3C3; op_b = 11'h1E7; in_valid = 1'b1;
      @(negedge clk);
      chk("R8 reset beats capture", product, '0);
      chk("R8 reset clears valid", PW'(out_valid), '0);
      in_valid = 1'b0; rst_n = 1'b1;
   endtask

   initial begin
      #20000000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      t_reset;
      t_zero;
      t_identity;
      t_all_ones;
      t_random;
      t_hold;
      t_back_to_back;
      t_reset_vs_capture;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule